// File: doc/BRIEF.md
# USB Start-of-Frame Watch with Keep-Alive Timeout

This block sits behind a USB device-side packet decoder and tracks bus liveness. In full-speed operation it records the 11-bit frame value carried by each start-of-frame token. In low-speed operation it treats each end-of-packet keep-alive marker as the liveness signal and leaves the frame value untouched. A watchdog counts clock ticks since the last liveness mark. When a programmable period passes with no mark, it produces a single timeout event and then starts counting again.

Timeout events set a sticky flag and advance a small saturating counter while the timeout interrupt is enabled. Any received mark clears that counter. Software reads the frame value, the counter and the flag through one 16-bit status word. An interrupt line is raised while the flag is set and the interrupt is enabled.

Top module: `usb_sof_watch`

## Requirements
- R1: In full-speed mode (`low_speed_i`=0), a `sof_valid_i` pulse loads `sof_frame_i` into status bits 10:0 on the next clock edge.
- R2: Status bits 10:0 keep their value through timeouts, through end-of-packet marks, and through `sof_valid_i` pulses taken in low-speed mode (`low_speed_i`=1).
- R3: The watchdog restarts on every liveness mark: `sof_valid_i` in full-speed mode, `eop_seen_i` in low-speed mode. After `tmo_period_i` consecutive cycles without a mark it produces one timeout event and restarts.
- R4: A `tmo_period_i` of 0 disables the watchdog, so no timeout events occur.
- R5: Status bits 14:12 hold a timeout counter. It rises by one for each timeout event while `tmo_irq_en_i` is 1, and it is left unchanged by timeouts while `tmo_irq_en_i` is 0.
- R6: The timeout counter saturates at 7.
- R7: The timeout counter returns to 0 on any `sof_valid_i` or `eop_seen_i` pulse, in either mode and regardless of `tmo_irq_en_i`.
- R8: A liveness mark in the same cycle as a watchdog expiry wins: the watchdog restarts and no timeout is counted or flagged.
- R9: Status bit 15 is set by every timeout event and stays set until a `flag_clr_i` pulse clears it. When a clear and a timeout fall in the same cycle, the clear wins.
- R10: Status bit 11 always reads 0.
- R11: `irq_o` is 1 exactly when status bit 15 is 1 and `tmo_irq_en_i` is 1.
- R12: After reset the status word is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_valid_i | input | 1 | One-cycle pulse for a received start-of-frame token |
| sof_frame_i | input | 11 | Frame value accompanying `sof_valid_i` |
| eop_seen_i | input | 1 | One-cycle pulse for a received end-of-packet keep-alive |
| low_speed_i | input | 1 | 1 selects low-speed mode, 0 selects full-speed mode |
| tmo_irq_en_i | input | 1 | Timeout interrupt enable |
| tmo_period_i | input | PERIOD_W | Watchdog period in clock cycles, 0 disables |
| flag_clr_i | input | 1 | One-cycle pulse that clears the timeout flag |
| status_o | output | 16 | {flag, count[2:0], 0, frame[10:0]} |
| irq_o | output | 1 | Timeout interrupt request |

## Verification
Two collisions matter here. The first is a liveness mark arriving in the expiry cycle. The second is a flag clear arriving in the expiry cycle. Both are provoked by setting the period to one cycle, which makes the watchdog expire on every idle cycle. The bench then drives either a start-of-frame pulse every cycle or periodic clear pulses. A per-cycle reference model judges the result: the counter must stay at 0 under the first collision, and the flag must read 0 in the cycle after each clear under the second. Random traffic adds further chance collisions of both kinds.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
    localparam int FRAME_W  = 11;
    localparam int CNT_W    = 3;
    localparam int STATUS_W = 16;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic               flag;
        logic [CNT_W-1:0]   count;
        logic [FRAME_W-1:0] frame;
    } sfw_state_t;
endpackage

// File: rtl/sfw_watchdog.sv
module sfw_watchdog #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                expire_o
);
    logic [PERIOD_W-1:0] tick_d, tick_q;
    logic [PERIOD_W-1:0] last_tick;
    logic                armed;

    always_comb begin
        last_tick = period_i - PERIOD_W'(1);
        armed     = (period_i != '0);
        expire_o  = 1'b0;
        tick_d    = tick_q + PERIOD_W'(1);
        if (restart_i || !armed) begin
            tick_d = '0;
        end else if (tick_q >= last_tick) begin
            expire_o = 1'b1;
            tick_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end
endmodule

// File: rtl/sfw_status.sv
module sfw_status
    import sfw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_we_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               any_mark_i,
    input  logic               expire_i,
    input  logic               irq_en_i,
    input  logic               flag_clr_i,
    output sfw_state_t         state_o
);
    sfw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_we_i) st_d.frame = frame_i;
        if (any_mark_i) begin
            st_d.count = '0;
        end else if (expire_i && irq_en_i && (st_q.count != CNT_MAX)) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
        if (flag_clr_i)    st_d.flag = 1'b0;
        else if (expire_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/usb_sof_watch.sv
module usb_sof_watch
    import sfw_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_valid_i,
    input  logic [FRAME_W-1:0]  sof_frame_i,
    input  logic                eop_seen_i,
    input  logic                low_speed_i,
    input  logic                tmo_irq_en_i,
    input  logic [PERIOD_W-1:0] tmo_period_i,
    input  logic                flag_clr_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                irq_o
);
    logic       live_mark;
    logic       any_mark;
    logic       frame_we;
    logic       expire;
    sfw_state_t state;

    always_comb begin
        live_mark = low_speed_i ? eop_seen_i : sof_valid_i;
        any_mark  = sof_valid_i | eop_seen_i;
        frame_we  = sof_valid_i & ~low_speed_i;
    end

    sfw_watchdog #(.PERIOD_W(PERIOD_W)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(live_mark),
        .period_i (tmo_period_i),
        .expire_o (expire)
    );

    sfw_status u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_we_i(frame_we),
        .frame_i   (sof_frame_i),
        .any_mark_i(any_mark),
        .expire_i  (expire),
        .irq_en_i  (tmo_irq_en_i),
        .flag_clr_i(flag_clr_i),
        .state_o   (state)
    );

    assign status_o = {state.flag, state.count, 1'b0, state.frame};
    assign irq_o    = state.flag & tmo_irq_en_i;
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker
    import sfw_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                sof_valid_i,
    input logic                eop_seen_i,
    input logic                low_speed_i,
    input logic                tmo_irq_en_i,
    input logic                flag_clr_i,
    input logic                expire,
    input logic [STATUS_W-1:0] status_o
);
    logic [CNT_W-1:0] cnt;
    assign cnt = status_o[14:12];

    // R2
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof_valid_i && !low_speed_i) |=> $stable(status_o[10:0]));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && tmo_irq_en_i && !sof_valid_i && !eop_seen_i && cnt != CNT_MAX)
        |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R6
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !sof_valid_i && !eop_seen_i) |=> (cnt == CNT_MAX));

    // R7
    count_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_valid_i || eop_seen_i) |=> (cnt == '0));

    // R8
    mark_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_speed_i ? eop_seen_i : sof_valid_i) |-> !expire);

    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i |=> !status_o[15]);
endmodule

bind usb_sof_watch sfw_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_valid_i (sof_valid_i),
    .eop_seen_i  (eop_seen_i),
    .low_speed_i (low_speed_i),
    .tmo_irq_en_i(tmo_irq_en_i),
    .flag_clr_i  (flag_clr_i),
    .expire      (expire),
    .status_o    (status_o)
);

// File: tb/usb_sof_watch_tb_top.sv
`timescale 1ns/1ps
module usb_sof_watch_tb_top;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sof_valid = 1'b0;
    logic [10:0]   sof_frame = '0;
    logic          eop_seen = 1'b0;
    logic          low_speed = 1'b0;
    logic          irq_en = 1'b0;
    logic [PW-1:0] period = '0;
    logic          flag_clr = 1'b0;
    logic [15:0]   status;
    logic          irq;

    int errs = 0;
    int checks = 0;

    // reference model state
    logic [10:0]   m_frame = '0;
    logic [2:0]    m_cnt = '0;
    logic          m_flag = 1'b0;
    logic [PW-1:0] m_tick = '0;

    always #2.5 clk = ~clk;

    usb_sof_watch #(.PERIOD_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sof_valid_i(sof_valid), .sof_frame_i(sof_frame),
        .eop_seen_i(eop_seen), .low_speed_i(low_speed), .tmo_irq_en_i(irq_en),
        .tmo_period_i(period), .flag_clr_i(flag_clr), .status_o(status), .irq_o(irq)
    );

    function automatic logic model_expire(logic live, logic [PW-1:0] per, logic [PW-1:0] tk);
        if (live || per == '0) return 1'b0;
        return (tk >= per - PW'(1));
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1 R2 frame", int'(status[10:0]), int'(m_frame));
        check("R3 R4 R5 R6 R7 R8 count", int'(status[14:12]), int'(m_cnt));
        check("R9 flag", int'(status[15]), int'(m_flag));
        check("R10 reserved", int'(status[11]), 0);
        check("R11 irq", int'(irq), int'(m_flag & irq_en));
    endtask

    task automatic step();
        logic live, ex;
        @(posedge clk);
        live = low_speed ? eop_seen : sof_valid;
        ex   = model_expire(live, period, m_tick);
        if (live || period == '0 || ex) m_tick = '0;
        else m_tick = m_tick + PW'(1);
        if (sof_valid && !low_speed) m_frame = sof_frame;
        if (sof_valid || eop_seen) m_cnt = '0;
        else if (ex && irq_en && m_cnt != 3'd7) m_cnt = m_cnt + 3'd1;
        if (flag_clr) m_flag = 1'b0;
        else if (ex) m_flag = 1'b1;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        sof_valid = 0; eop_seen = 0; flag_clr = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #200000;
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 status", int'(status), 0);
        check("R12 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: capture a frame in full-speed mode, then idle to saturation (R5, R6)
        period = 16'd4; irq_en = 1;
        sof_valid = 1; sof_frame = 11'h5A5; step();
        idle(40);
        check("R6 saturated", int'(status[14:12]), 7);
        check("R2 frame held", int'(status[10:0]), 'h5A5);

        // R2: low-speed mode ignores SOF frame value; EOP clears count (R7)
        low_speed = 1;
        sof_valid = 1; sof_frame = 11'h123; step();
        check("R2 ls frame", int'(status[10:0]), 'h5A5);
        eop_seen = 1; step();
        idle(10);

        // R5: disabled interrupt freezes the counter
        irq_en = 0; eop_seen = 1; step(); idle(20);
        check("R5 frozen", int'(status[14:12]), 0);
        irq_en = 1;

        // R8: mark every cycle with period 1
        low_speed = 0; period = 16'd1;
        for (int i = 0; i < 12; i++) begin
            sof_valid = 1; sof_frame = 11'(i); step();
        end
        idle(1);

        // R9: clear colliding with an expiry every cycle
        for (int i = 0; i < 10; i++) begin
            flag_clr = 1; step();
            flag_clr = 0; step();
        end

        // R4: period 0 disables the watchdog
        flag_clr = 1; step(); flag_clr = 0;
        sof_valid = 1; step();
        period = '0; idle(30);
        check("R4 no timeout", int'(status[15]), 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            sof_valid = ($urandom_range(0, 29) == 0);
            sof_frame = 11'($urandom);
            eop_seen  = ($urandom_range(0, 29) == 0);
            flag_clr  = ($urandom_range(0, 24) == 0);
            if ($urandom_range(0, 199) == 0) low_speed = ~low_speed;
            if ($urandom_range(0, 99) == 0) irq_en = ~irq_en;
            if ($urandom_range(0, 149) == 0) period = PW'($urandom_range(0, 12));
            step();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule